// File: doc/BRIEF.md
# Linear Volume Fader

This block generates a volume level for an audio sample path, expressed in tenths of a percent on a scale from 0 to `FULL_SCALE` (1000 by default, meaning 100 %). When commanded it ramps that level up from silence or down from full volume, moving by one fixed unit each time a programmable number of microsecond ticks has elapsed. The ramp halts itself when it reaches the end of the scale.

A fade-in command drops the level to 0 and starts climbing. A fade-out command first snaps the level to full scale and then descends. Either command restarts the ramp from scratch and abandons any fade already under way. The step interval is captured when the command arrives. A free-running one-microsecond strobe paces the ramp, so the fade duration is the step interval multiplied by the number of steps.

Top module: `vol_fader`

## Requirements
- R1: The `level` output never exceeds `FULL_SCALE`.
- R2: While reset is asserted, and after it is released with no command, `level` equals `FULL_SCALE` and `busy` is low.
- R3: One cycle after `fade_in_req` is sampled high (with `fade_out_req` low), `level` is 0 and `busy` is high.
- R4: One cycle after `fade_out_req` is sampled high, `level` equals `FULL_SCALE` and `busy` is high.
- R5: When both requests are high in the same cycle, the fade-out command wins.
- R6: During a fade, `level` moves by exactly `STEP` (one unit by default) after every `step_ivl` cycles in which `us_tick` is high. It never moves in a cycle without `us_tick`.
- R7: `step_ivl` is captured when a command is accepted, and later changes do not alter the running fade. A captured value of 0 behaves like 1.
- R8: A rising fade that reaches or would pass `FULL_SCALE` settles exactly at `FULL_SCALE` and drops `busy` in that same cycle.
- R9: A falling fade that reaches or would pass 0 settles exactly at 0 and drops `busy` in that same cycle.
- R10: A command issued during a running fade discards it, including any partial tick count, and starts the new fade.
- R11: While `busy` is low and no command arrives, `us_tick` pulses leave `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| fade_in_req | input | 1 | Start a rising fade from 0 |
| fade_out_req | input | 1 | Start a falling fade from full scale |
| step_ivl | input | IVL_W | Microsecond ticks per step |
| level | output | LVL_W | Volume in tenths of a percent |
| busy | output | 1 | High while a fade is running |

## Verification
The bench builds the block with `FULL_SCALE` = 1000 and `STEP` = 1, which are the defaults, and narrows `IVL_W` to 8. With these values both complete ramps fit easily in the run: 1000 steps at an interval of one tick, so the two clamps at 0 and at 1000 are actually reached. Intervals of 0, 1, 2, 3 and 4 exercise the treatment of a zero interval as 1, the handling of partial tick counts, and the capture of the interval at command time.

// File: rtl/vol_fader_pkg.sv
package vol_fader_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/vol_fader_rst_sync.sv
module vol_fader_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/vol_fader_step_timer.sv
module vol_fader_step_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  input  logic [IVL_W-1:0] ivl_in,
  output logic             step
);
  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic [IVL_W-1:0] last_q, last_d;
  logic             cnt_en;
  logic [IVL_W-1:0] ivl_eff;

  // zero interval is promoted to one tick per step
  assign ivl_eff = (ivl_in == '0) ? IVL_W'(1) : ivl_in;
  assign step    = run && tick && (cnt_q == last_q);
  assign cnt_en  = start || (run && tick);

  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    if (start) begin
      cnt_d  = '0;
      last_d = ivl_eff - IVL_W'(1);
    end else if (step) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + IVL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/vol_fader_level_reg.sv
module vol_fader_level_reg
  import vol_fader_pkg::*;
#(
  parameter int FULL_SCALE = 1000,
  parameter int STEP       = 1,
  parameter int LVL_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_up,
  input  logic             start_down,
  input  logic             step,
  output logic [LVL_W-1:0] level,
  output logic             busy
);
  localparam logic [LVL_W-1:0] FULL_V = LVL_W'(FULL_SCALE);
  localparam logic [LVL_W-1:0] STEP_V = LVL_W'(STEP);
  localparam logic [LVL_W-1:0] HIGH_V = LVL_W'(FULL_SCALE - STEP);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             busy_q, busy_d;
  ramp_dir_e        dir_q, dir_d;
  logic             upd_en;

  assign upd_en = start_up || start_down || (step && busy_q);

  always_comb begin
    lvl_d  = lvl_q;
    busy_d = busy_q;
    dir_d  = dir_q;
    if (start_down) begin
      lvl_d  = FULL_V;
      busy_d = 1'b1;
      dir_d  = DIR_DOWN;
    end else if (start_up) begin
      lvl_d  = '0;
      busy_d = 1'b1;
      dir_d  = DIR_UP;
    end else if (dir_q == DIR_UP) begin
      if (lvl_q >= HIGH_V) begin
        lvl_d  = FULL_V;
        busy_d = 1'b0;
      end else begin
        lvl_d = lvl_q + STEP_V;
      end
    end else begin
      if (lvl_q <= STEP_V) begin
        lvl_d  = '0;
        busy_d = 1'b0;
      end else begin
        lvl_d = lvl_q - STEP_V;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= FULL_V;
      busy_q <= 1'b0;
      dir_q  <= DIR_UP;
    end else if (upd_en) begin
      lvl_q  <= lvl_d;
      busy_q <= busy_d;
      dir_q  <= dir_d;
    end
  end

  assign level = lvl_q;
  assign busy  = busy_q;
endmodule

// File: rtl/vol_fader.sv
module vol_fader #(
  parameter  int FULL_SCALE = 1000,
  parameter  int STEP       = 1,
  parameter  int IVL_W      = 16,
  localparam int LVL_W      = $clog2(FULL_SCALE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             fade_in_req,
  input  logic             fade_out_req,
  input  logic [IVL_W-1:0] step_ivl,
  output logic [LVL_W-1:0] level,
  output logic             busy
);
  logic rst_q_n;
  logic go_down, go_up, go_any;
  logic step_pulse;

  // fade-out has priority over a simultaneous fade-in
  assign go_down = fade_out_req;
  assign go_up   = fade_in_req && !fade_out_req;
  assign go_any  = go_down || go_up;

  vol_fader_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  vol_fader_step_timer #(.IVL_W(IVL_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_q_n),
    .start (go_any),
    .run   (busy),
    .tick  (us_tick),
    .ivl_in(step_ivl),
    .step  (step_pulse)
  );

  vol_fader_level_reg #(
    .FULL_SCALE(FULL_SCALE),
    .STEP      (STEP),
    .LVL_W     (LVL_W)
  ) u_level (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start_up  (go_up),
    .start_down(go_down),
    .step      (step_pulse),
    .level     (level),
    .busy      (busy)
  );
endmodule

// File: rtl/vol_fader_chk.sv
module vol_fader_chk #(
  parameter int FULL_SCALE = 1000,
  parameter int STEP       = 1,
  parameter int LVL_W      = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             us_tick,
  input logic             fade_in_req,
  input logic             fade_out_req,
  input logic [LVL_W-1:0] level,
  input logic             busy
);
  logic no_cmd;
  assign no_cmd = !fade_in_req && !fade_out_req;

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= FULL_SCALE); // R1

  AST_FADE_IN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fade_in_req && !fade_out_req) |=> (level == '0) && busy); // R3

  AST_FADE_OUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    fade_out_req |=> (int'(level) == FULL_SCALE) && busy); // R4

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!us_tick && no_cmd) |=> $stable(level) && $stable(busy)); // R6

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && no_cmd) |=> (int'(level) == int'($past(level))) ||
                         (int'(level) - int'($past(level)) == STEP) ||
                         (int'($past(level)) - int'(level) == STEP) ||
                         (!busy)); // R6

  AST_STOP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && no_cmd) |=> busy || (level == '0) || (int'(level) == FULL_SCALE)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && no_cmd) |=> $stable(level) && !busy); // R11
endmodule

bind vol_fader vol_fader_chk #(
  .FULL_SCALE(FULL_SCALE),
  .STEP      (STEP),
  .LVL_W     (LVL_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .us_tick     (us_tick),
  .fade_in_req (fade_in_req),
  .fade_out_req(fade_out_req),
  .level       (level),
  .busy        (busy)
);

// File: tb/vol_fader_tb_top.sv
module vol_fader_tb_top;
  localparam int FULL  = 1000;
  localparam int IVL_W = 8;
  localparam int LVL_W = $clog2(FULL + 1);

  typedef struct packed {
    logic [1:0]  cmd;   // 0 none, 1 fade-in, 2 fade-out
    logic [7:0]  ivl;
    logic [15:0] ticks;
    logic [15:0] exp_lvl;
    logic        exp_busy;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'd4, 16'd0,    16'd0,    1'b1},  // R3 fade-in starts at 0
    '{2'd0, 8'd4, 16'd3,    16'd0,    1'b1},  // R6 no step before interval
    '{2'd0, 8'd4, 16'd1,    16'd1,    1'b1},  // R6 first step
    '{2'd0, 8'd4, 16'd8,    16'd3,    1'b1},  // R6 two more steps
    '{2'd2, 8'd2, 16'd0,    16'd1000, 1'b1},  // R4 R10 fade-out restarts at full
    '{2'd0, 8'd2, 16'd5,    16'd998,  1'b1},  // R6 partial interval kept
    '{2'd1, 8'd1, 16'd999,  16'd999,  1'b1},  // R10 restart upward
    '{2'd0, 8'd1, 16'd1,    16'd1000, 1'b0},  // R8 clamp at full scale
    '{2'd0, 8'd1, 16'd5,    16'd1000, 1'b0},  // R11 idle ignores ticks
    '{2'd2, 8'd1, 16'd1000, 16'd0,    1'b0},  // R9 clamp at zero
    '{2'd0, 8'd1, 16'd3,    16'd0,    1'b0},  // R11 idle at zero
    '{2'd1, 8'd0, 16'd2,    16'd2,    1'b1},  // R7 zero interval acts as 1
    '{2'd1, 8'd3, 16'd0,    16'd0,    1'b1},  // R7 capture interval 3
    '{2'd0, 8'd1, 16'd3,    16'd1,    1'b1}   // R7 later change ignored
  };

  logic             clk;
  logic             rst_n;
  logic             us_tick;
  logic             fade_in_req;
  logic             fade_out_req;
  logic [IVL_W-1:0] step_ivl;
  logic [LVL_W-1:0] level;
  logic             busy;

  int n_chk;
  int n_err;

  vol_fader #(.FULL_SCALE(FULL), .STEP(1), .IVL_W(IVL_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .us_tick     (us_tick),
    .fade_in_req (fade_in_req),
    .fade_out_req(fade_out_req),
    .step_ivl    (step_ivl),
    .level       (level),
    .busy        (busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int exp_lvl, input logic exp_busy);
    n_chk++;
    if (int'(level) != exp_lvl || busy != exp_busy) begin
      n_err++;
      $display("FAIL %s: level=%0d busy=%0b expected level=%0d busy=%0b",
               req, level, busy, exp_lvl, exp_busy);
    end
  endtask

  task automatic issue(input logic in_r, input logic out_r, input logic [IVL_W-1:0] ivl);
    @(negedge clk);
    fade_in_req  = in_r;
    fade_out_req = out_r;
    step_ivl     = ivl;
    @(negedge clk);
    fade_in_req  = 1'b0;
    fade_out_req = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      us_tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      us_tick = 1'b0;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    us_tick = 1'b0;
    fade_in_req = 1'b0;
    fade_out_req = 1'b0;
    step_ivl = '0;
    repeat (3) @(negedge clk);
    check("R2 in reset", FULL, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 after release", FULL, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].cmd == 2'd1) issue(1'b1, 1'b0, VECS[i].ivl);
      else if (VECS[i].cmd == 2'd2) issue(1'b0, 1'b1, VECS[i].ivl);
      else begin
        @(negedge clk);
        step_ivl = VECS[i].ivl;
      end
      run_ticks(int'(VECS[i].ticks));
      check($sformatf("vector %0d", i), int'(VECS[i].exp_lvl), VECS[i].exp_busy);
    end

    // R5 simultaneous requests: fade-out wins, then ramps down
    issue(1'b1, 1'b1, 8'd1);
    check("R5 both requests", FULL, 1'b1);
    run_ticks(1);
    check("R5 direction down", FULL - 1, 1'b1);

    // R6 no movement without ticks
    issue(1'b1, 1'b0, 8'd1);
    repeat (10) @(negedge clk);
    check("R6 no tick hold", 0, 1'b1);

    // R2 reset during a fade
    run_ticks(4);
    check("R6 four steps", 4, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R2 reset mid-fade", FULL, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_ticks(3);
    check("R11 idle after reset", FULL, 1'b0);

    summary();
  end
endmodule